// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Tracker

This block watches the command stream sent to a four-bank DDR SDRAM and decides, cycle by cycle, whether each command obeys the row-state and spacing rules. It decodes the active-low chip-select, row-strobe, column-strobe and write-enable lines into ACTIVE, READ, WRITE, PRECHARGE or no-operation. It then checks the command against the state of each bank and against timing windows counted in clock cycles. It also shows which banks have a row open and which row that is.

The three timing limits are parameters in picoseconds, together with the clock period. They are turned into cycle counts by dividing and rounding up. For example, a 15 ns row-to-column delay at a 6 ns clock gives 3 cycles. Each bank keeps its own row-to-column and activate-to-activate down-counters. A single shared counter spaces activations to different banks. A command that breaks a rule is flagged at once through a combinational legality output. It is also reported one cycle later as a pulse with a code that names the rule broken. A rejected command leaves the tracked state as it was.

Top module: `sdram_act_tracker`

## Requirements
- R1: A command is sampled only when `cke` is 1. The encoding of (cs_n, ras_n, cas_n, we_n) is 0011 for ACTIVE, 0101 for READ, 0100 for WRITE and 0010 for PRECHARGE. Every other pattern, and any cycle with `cke` at 0, is legal and changes no state.
- R2: An accepted ACTIVE opens bank `ba` and records `addr` as its row. After that edge, `row_open[i]` shows whether bank i is open, and `open_rows[i*12 +: 12]` holds the row of bank i.
- R3: A READ or WRITE to a bank with no open row is illegal, with code 1.
- R4: A READ or WRITE to an open bank fewer than TRCD cycles after that bank's ACTIVE is illegal, with code 2. The first legal column command comes on the TRCD-th clock edge after the ACTIVE edge.
- R5: An ACTIVE to a bank that is already open is illegal, with code 3. An ACTIVE to an idle bank fewer than TRC cycles after that bank's previous ACTIVE is illegal, with code 4.
- R6: An ACTIVE to a bank other than the most recently activated one, issued fewer than TRRD cycles after that most recent ACTIVE, is illegal, with code 5. This rule does not apply to the same bank.
- R7: When several rules are broken at once, a column command reports code 1 before code 2, and an ACTIVE reports code 3 before code 4, and code 4 before code 5.
- R8: A PRECHARGE closes bank `ba`. When `addr[10]` is 1 it closes all banks. A PRECHARGE to an idle bank is legal and has no effect. Closing a bank does not restart its TRC window.
- R9: For an illegal command, `cmd_legal` is 0 in the same cycle. After that edge, `viol` is 1 for exactly one cycle and `viol_code` holds the rule code. The bank state stays unchanged. For a legal command, `viol` is 0 and `viol_code` is 0 after the edge.
- R10: Each limit is converted as ceil(limit_ps / period_ps). The defaults (6000 ps clock, 15000, 60000 and 12000 ps limits) give TRCD=3, TRC=10 and TRRD=2.
- R11: After reset all banks are idle, `viol` is 0 and all counters are zero, so the first ACTIVE is legal at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable; commands are sampled only when it is 1 |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 12 | Row address for ACTIVE; bit 10 selects all banks for PRECHARGE |
| cmd_legal | output | 1 | Combinational: the present command breaks no rule |
| viol | output | 1 | One-cycle pulse after an illegal command |
| viol_code | output | 3 | Rule broken: 0 none, 1 idle column access, 2 tRCD, 3 bank open, 4 tRC, 5 tRRD |
| row_open | output | 4 | One bit per bank, 1 when a row is open |
| open_rows | output | 48 | Open row of each bank, 12 bits per bank |

## Verification
The bench goes after the exact window edges. A column command at TRCD-1 cycles after ACTIVE must be refused, and the same command at TRCD cycles must be accepted; a counter loaded one off would move that boundary. Back-to-back activations to different banks probe tRRD. A quick reactivation after precharge probes tRC: a design that restarts or clears the window on precharge would accept it too early. The bench also checks that when rules overlap the code follows the stated priority, and that precharge-all, precharge of an idle bank, and commands with clock enable low leave the state as the reference model expects. A design that let a rejected command update a bank would open rows the model does not show.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        V_NONE     = 3'd0,
        V_COL_IDLE = 3'd1,
        V_COL_RCD  = 3'd2,
        V_ACT_OPEN = 3'd3,
        V_ACT_RC   = 3'd4,
        V_ACT_RRD  = 3'd5
    } viol_e;

    // ceiling division used to turn a time limit into whole clock cycles
    function automatic int unsigned ps_to_cyc(input int unsigned lim_ps, input int unsigned tck_ps);
        return (lim_ps + tck_ps - 1) / tck_ps;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_trk_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (cke && !cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer #(
    parameter int ROW_W   = 12,
    parameter int RCD_CYC = 3,
    parameter int RC_CYC  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_ld,
    input  logic             pre_clr,
    input  logic [ROW_W-1:0] act_row,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             rcd_done,
    output logic             rc_done
);

    localparam int RCD_W = (RCD_CYC > 1) ? $clog2(RCD_CYC) : 1;
    localparam int RC_W  = (RC_CYC > 1) ? $clog2(RC_CYC) : 1;
    localparam logic [RCD_W-1:0] RCD_LD = RCD_W'((RCD_CYC > 0) ? RCD_CYC - 1 : 0);
    localparam logic [RC_W-1:0]  RC_LD  = RC_W'((RC_CYC > 0) ? RC_CYC - 1 : 0);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [RCD_W-1:0] rcd;
        logic [RC_W-1:0]  rc;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.rcd != '0) st_d.rcd = st_q.rcd - 1'b1;
        if (st_q.rc != '0)  st_d.rc  = st_q.rc - 1'b1;
        if (act_ld) begin
            st_d.open = 1'b1;
            st_d.row  = act_row;
            st_d.rcd  = RCD_LD;
            st_d.rc   = RC_LD;
        end else if (pre_clr) begin
            st_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign is_open  = st_q.open;
    assign open_row = st_q.row;
    assign rcd_done = (st_q.rcd == '0);
    assign rc_done  = (st_q.rc == '0);

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        act_ld |=> (is_open && open_row == $past(act_row))); // R2
    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_clr && !act_ld) |=> !is_open); // R8
    AST_RC_HOLDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_done && !act_ld) |=> rc_done); // R5
    AST_RCD_HOLDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rcd_done && !act_ld) |=> rcd_done); // R4

endmodule

// File: rtl/sdram_act_tracker.sv
module sdram_act_tracker
    import sdram_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int TCK_PS    = 6000,
    parameter int TRCD_PS   = 15000,
    parameter int TRC_PS    = 60000,
    parameter int TRRD_PS   = 12000,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cke,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [BA_W-1:0]            ba,
    input  logic [ROW_W-1:0]           addr,
    output logic                       cmd_legal,
    output logic                       viol,
    output logic [2:0]                 viol_code,
    output logic [NUM_BANKS-1:0]       row_open,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows
);

    localparam int RCD_CYC = int'(ps_to_cyc(TRCD_PS, TCK_PS));
    localparam int RC_CYC  = int'(ps_to_cyc(TRC_PS, TCK_PS));
    localparam int RRD_CYC = int'(ps_to_cyc(TRRD_PS, TCK_PS));
    localparam int RRD_W   = (RRD_CYC > 1) ? $clog2(RRD_CYC) : 1;
    localparam logic [RRD_W-1:0] RRD_LD = RRD_W'((RRD_CYC > 0) ? RRD_CYC - 1 : 0);
    localparam int ALL_BIT = 10;

    typedef struct packed {
        logic [RRD_W-1:0] rrd;
        logic [BA_W-1:0]  last_ba;
        logic             viol;
        viol_e            code;
    } glob_st_t;

    glob_st_t g_d, g_q;
    cmd_e     cmd;
    viol_e    code;
    logic [NUM_BANKS-1:0] act_ld, pre_clr, rcd_done, rc_done;

    sdram_cmd_decode u_dec (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        sdram_bank_timer #(
            .ROW_W   (ROW_W),
            .RCD_CYC (RCD_CYC),
            .RC_CYC  (RC_CYC)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_ld   (act_ld[i]),
            .pre_clr  (pre_clr[i]),
            .act_row  (addr),
            .is_open  (row_open[i]),
            .open_row (open_rows[i*ROW_W +: ROW_W]),
            .rcd_done (rcd_done[i]),
            .rc_done  (rc_done[i])
        );
    end

    always_comb begin
        code = V_NONE;
        unique case (cmd)
            CMD_RD, CMD_WR: begin
                if (!row_open[ba])      code = V_COL_IDLE;
                else if (!rcd_done[ba]) code = V_COL_RCD;
            end
            CMD_ACT: begin
                if (row_open[ba])                              code = V_ACT_OPEN;
                else if (!rc_done[ba])                         code = V_ACT_RC;
                else if (ba != g_q.last_ba && g_q.rrd != '0)   code = V_ACT_RRD;
            end
            default: code = V_NONE;
        endcase
    end

    assign cmd_legal = (code == V_NONE);

    always_comb begin
        g_d     = g_q;
        act_ld  = '0;
        pre_clr = '0;
        if (g_q.rrd != '0) g_d.rrd = g_q.rrd - 1'b1;
        if (cmd == CMD_ACT && cmd_legal) begin
            act_ld[ba]  = 1'b1;
            g_d.rrd     = RRD_LD;
            g_d.last_ba = ba;
        end
        if (cmd == CMD_PRE) begin
            if (addr[ALL_BIT]) pre_clr = '1;
            else               pre_clr[ba] = 1'b1;
        end
        g_d.viol = !cmd_legal;
        g_d.code = code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{rrd: '0, last_ba: '0, viol: 1'b0, code: V_NONE};
        else        g_q <= g_d;
    end

    assign viol      = g_q.viol;
    assign viol_code = g_q.code;

    AST_VIOL_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (viol_code != 3'd0)); // R9
    AST_REJECT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (row_open == $past(row_open) && open_rows == $past(open_rows))); // R9
    AST_COL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_RD || cmd == CMD_WR) && cmd_legal) |-> row_open[ba]); // R3
    AST_RRD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (RRD_CYC >= 2 && act_ld != '0) |=> !(act_ld != '0 && ba != $past(ba))); // R6
    AST_ONE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_ld)); // R2

endmodule

// File: tb/tb_sdram_act_tracker.sv
module tb_sdram_act_tracker;

    localparam int NB = 4;
    localparam int RW = 12;

    function automatic int cyc_of(input int lim, input int tck);
        return (lim + tck - 1) / tck;
    endfunction

    localparam int E_RCD = 3;
    localparam int E_RC  = 10;
    localparam int E_RRD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic [RW-1:0] addr = '0;
    logic cmd_legal, viol;
    logic [2:0] viol_code;
    logic [NB-1:0] row_open;
    logic [NB*RW-1:0] open_rows;

    always #10 clk = ~clk;

    sdram_act_tracker dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_legal(cmd_legal), .viol(viol), .viol_code(viol_code),
        .row_open(row_open), .open_rows(open_rows)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    bit m_open [NB];
    int m_row  [NB];
    int m_act  [NB];
    int m_last_cyc = -1000;
    int m_last_ba  = 0;
    int cyc = 0;

    // command kinds: 0 nop, 1 act, 2 rd, 3 wr, 4 pre, 5 other (refresh-like)
    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cyc %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int model_code(input int k, input int b, input bit ck);
        if (!ck) return 0;
        if (k == 2 || k == 3) begin
            if (!m_open[b]) return 1;
            if (cyc - m_act[b] < E_RCD) return 2;
            return 0;
        end
        if (k == 1) begin
            if (m_open[b]) return 3;
            if (cyc - m_act[b] < E_RC) return 4;
            if (b != m_last_ba && cyc - m_last_cyc < E_RRD) return 5;
            return 0;
        end
        return 0;
    endfunction

    task automatic issue(input int k, input int b, input int a, input bit ck);
        int exp_code;
        @(negedge clk);
        cke = ck;
        ba = 2'(b);
        addr = RW'(a);
        case (k)
            1: {cs_n, ras_n, cas_n, we_n} = 4'b0011;
            2: {cs_n, ras_n, cas_n, we_n} = 4'b0101;
            3: {cs_n, ras_n, cas_n, we_n} = 4'b0100;
            4: {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            5: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        endcase
        exp_code = model_code(k, b, ck);
        #5;
        check(exp_code == 0 ? "R1/R9 legal" : (exp_code < 3 ? "R3/R4/R9 legal" : "R5/R6/R9 legal"),
              int'(cmd_legal), exp_code == 0 ? 1 : 0);
        @(posedge clk);
        #1;
        // update model
        if (ck && exp_code == 0) begin
            if (k == 1) begin
                m_open[b] = 1; m_row[b] = a; m_act[b] = cyc;
                m_last_cyc = cyc; m_last_ba = b;
            end else if (k == 4) begin
                if (a[10]) for (int i = 0; i < NB; i++) m_open[i] = 0;
                else m_open[b] = 0;
            end
        end
        check("R9 viol", int'(viol), exp_code != 0 ? 1 : 0);
        check(exp_code == 2 ? "R4 code" : (exp_code >= 3 ? "R5/R6/R7 code" : "R3/R7 code"),
              int'(viol_code), exp_code);
        for (int i = 0; i < NB; i++) begin
            check("R2/R8 row_open", int'(row_open[i]), int'(m_open[i]));
            if (m_open[i]) check("R2 open_rows", int'(open_rows[i*RW +: RW]), m_row[i]);
        end
        cyc++;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NB; i++) begin
            m_open[i] = 0; m_row[i] = 0; m_act[i] = -1000;
        end
        check("R10 trcd", cyc_of(15000, 6000), E_RCD);
        check("R10 trc", cyc_of(60000, 6000), E_RC);
        check("R10 trrd", cyc_of(12000, 6000), E_RRD);
        repeat (3) @(posedge clk);
        #1;
        check("R11 row_open reset", int'(row_open), 0);
        check("R11 viol reset", int'(viol), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corner cases (model supplies expectations)
        issue(1, 0, 12'h123, 1);   // R11 first ACT legal at once
        issue(1, 1, 12'h456, 1);   // R6 tRRD violation
        issue(1, 1, 12'h456, 1);   // R6 now legal
        issue(2, 0, 0, 1);         // R4 exactly TRCD after: legal
        issue(3, 1, 0, 1);         // R4 TRCD-1: violation
        issue(2, 2, 0, 1);         // R3 idle bank
        issue(4, 0, 0, 1);         // R8 precharge bank 0
        issue(1, 0, 12'h0AA, 1);   // R5/R8 tRC still running
        issue(1, 1, 12'h0BB, 1);   // R5 bank already open
        issue(1, 2, 12'h0CC, 0);   // R1 cke low ignored
        issue(5, 2, 0, 1);         // R1 other pattern ignored
        issue(4, 3, 0, 1);         // R8 idle precharge no-op
        issue(4, 2, 12'h400, 1);   // R8 precharge all
        issue(3, 1, 0, 1);         // R3/R7 idle after precharge all
        repeat (4) issue(0, 0, 0, 1);
        issue(1, 0, 12'hFFF, 1);   // R5 tRC boundary
        issue(1, 0, 12'h001, 1);   // R7 open beats others
        issue(2, 0, 0, 1);

        for (int n = 0; n < 3000; n++) begin
            int r, k, b, a;
            r = int'($urandom_range(99));
            if (r < 30) k = 1;
            else if (r < 50) k = 2;
            else if (r < 65) k = 3;
            else if (r < 80) k = 4;
            else if (r < 88) k = 5;
            else k = 0;
            b = int'($urandom_range(3));
            a = int'($urandom_range(4095));
            if (k == 4 && $urandom_range(9) != 0) a = a & 12'hBFF;
            issue(k, b, a, $urandom_range(9) != 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule